// File: doc/BRIEF.md
# Single-Wire Bus Byte Transfer Engine

This block sits between a small register port and a bit-slot engine of a single-wire bus master. Software writes a byte into the shared data register. The engine then issues eight bit-slot requests, least significant bit first. Each request carries the bit to drive and is held until the slot engine acknowledges it. The acknowledge returns the level that was sampled on the wire, and the eight sampled levels are assembled into a received byte in the same register.

To read a byte from a device, software writes 0xFF. Every slot is then a write-1 slot, and the device can pull it low, so the sampled levels form the byte the device sent.

Four status flags track the transfer:
- the transmit holding buffer is empty;
- the transmit shifter has finished and nothing is pending;
- a received byte is waiting;
- the receive shifter is ready.

An enable register masks these flags onto a single interrupt line. A second byte may be written while the first is still on the wire. It waits in the holding buffer and follows the first byte without a gap in the transmit-shifter-empty flag.

Top module: `owb_byte_engine`

## Requirements
- R1: After reset the flag register (address 1) reads 0x2C, which means transmit-buffer-empty, transmit-shifter-empty and receive-shifter-ready are set and receive-buffer-full is clear. After reset the data register (address 0) reads 0x00, and `irq` and `slot_req` are low.
- R2: A write to the data register (address 0) starts eight bit slots. `slot_bit` presents the written byte least significant bit first, one bit per slot.
- R3: While `slot_req` is high and `slot_ack` is low, `slot_req` stays high and `slot_bit` is unchanged in the next cycle.
- R4: The `slot_sample` value returned with each acknowledge is shifted in least significant bit first. After the eighth slot the assembled byte is the value read from the data register. Writing 0xFF makes every slot a write-1 slot, so the received byte equals the device's response.
- R5: Flag bit 2 (transmit-buffer-empty) is clear in the cycle after a data-register write. It sets again when the byte moves into the shifter, which happens in the cycle after that write if the shifter is idle.
- R6: Flag bit 3 (transmit-shifter-empty) is clear from a data-register write until the eighth slot of the last pending byte is acknowledged. While it is set, `slot_req` is low.
- R7: Flag bit 4 (receive-buffer-full) sets only when the eighth slot of a byte is acknowledged. A read of the data register clears it, unless a new byte completes in the same cycle, in which case it stays set.
- R8: Flag bit 5 (receive-shifter-ready) is low while a byte is being shifted and high when the shifter is idle.
- R9: The enable register (address 2) reads back as written. `irq` is high exactly when some flag bit is set together with the same bit of the enable register.
- R10: A byte written while another is in flight is held and sent right after it. Its slots follow in order, and flag bit 3 stays clear until both bytes are complete.
- R11: `bus_rdata` carries the addressed register in the cycle after `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address: 0 data, 1 flags, 2 enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked OR of the flags |
| slot_req | output | 1 | Bit-slot request, held until acknowledged |
| slot_bit | output | 1 | Bit value for the requested slot |
| slot_ack | input | 1 | Slot complete strobe |
| slot_sample | input | 1 | Wire level sampled in the completed slot |

## Verification
The byte path is driven with three patterns:
- A mixed byte against a device response that clears some of its ones. The received byte is the AND of the two, which separates the sent value from the sampled value.
- 0xFF against a device byte, which shows that a read is a transmit of all ones.
- Two bytes written back to back, which checks slot order across the holding buffer and that transmit-shifter-empty stays clear until both bytes are done.

Slot acknowledges arrive after varying delays, so a request is held for one to three cycles and the held bit is checked on each of those cycles. Flags are read right after a write and again mid-transfer to tell the holding-buffer flag from the shifter flags. The interrupt mask is stepped across single flags.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam int ADDR_DATA  = 0;
  localparam int ADDR_FLAGS = 1;
  localparam int ADDR_ENA   = 2;
  localparam int FLG_TBE    = 2;
  localparam int FLG_TSE    = 3;
  localparam int FLG_RBF    = 4;
  localparam int FLG_RSR    = 5;
endpackage

// File: rtl/owb_slot_shifter.sv
module owb_slot_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              slot_ack,
  input  logic              slot_sample,
  output logic              busy,
  output logic              slot_bit,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;

  assign busy     = busy_q;
  assign slot_bit = tx_sh_q[0];
  assign rx_byte  = {slot_sample, rx_sh_q[DATA_W-1:1]};
  assign done     = busy_q && slot_ack && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (!busy_q) begin
      if (load) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        tx_sh_q <= load_data;
      end
    end else if (slot_ack) begin
      tx_sh_q <= {1'b0, tx_sh_q[DATA_W-1:1]};
      rx_sh_q <= rx_byte;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/owb_irq_unit.sv
module owb_irq_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] en_mask,
  output logic              irq
);
  logic [DATA_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  assign en_mask = en_q;
  assign irq     = |(flags & en_q);
endmodule

// File: rtl/owb_byte_engine.sv
module owb_byte_engine
  import owb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              slot_req,
  output logic              slot_bit,
  input  logic              slot_ack,
  input  logic              slot_sample
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(ADDR_DATA);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADDR_FLAGS);
  localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(ADDR_ENA);

  logic              wr_data, rd_data, wr_ena;
  logic [DATA_W-1:0] hold_q, rx_data_q, rdata_q;
  logic              hold_full_q, tse_q, rbf_q;
  logic              busy, done, load;
  logic [DATA_W-1:0] rx_byte, en_mask, flags;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_ena  = bus_wr && (bus_addr == A_ENA);
  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign load    = hold_full_q && !busy;

  always_comb begin
    flags          = '0;
    flags[FLG_TBE] = !hold_full_q;
    flags[FLG_TSE] = tse_q;
    flags[FLG_RBF] = rbf_q;
    flags[FLG_RSR] = !busy;
  end

  owb_slot_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_data  (hold_q),
    .slot_ack   (slot_ack),
    .slot_sample(slot_sample),
    .busy       (busy),
    .slot_bit   (slot_bit),
    .done       (done),
    .rx_byte    (rx_byte)
  );

  owb_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .en_we   (wr_ena),
    .en_wdata(bus_wdata),
    .flags   (flags),
    .en_mask (en_mask),
    .irq     (irq)
  );

  assign slot_req = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      tse_q       <= 1'b1;
      rbf_q       <= 1'b0;
      rx_data_q   <= '0;
    end else begin
      if (wr_data) begin
        hold_q      <= bus_wdata;
        hold_full_q <= 1'b1;
      end else if (load) begin
        hold_full_q <= 1'b0;
      end
      if (wr_data)   tse_q <= 1'b0;
      else if (done) tse_q <= !hold_full_q;
      if (done) begin
        rx_data_q <= rx_byte;
        rbf_q     <= 1'b1;
      end else if (rd_data) begin
        rbf_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_DATA:  rdata_q <= rx_data_q;
        A_FLAGS: rdata_q <= flags;
        A_ENA:   rdata_q <= en_mask;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/owb_byte_engine_chk.sv
module owb_byte_engine_chk
  import owb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              slot_req,
  input logic              slot_bit,
  input logic              slot_ack,
  input logic              done,
  input logic [DATA_W-1:0] flags
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_bit)));

  a_r6_tse_idle: assert property (@(posedge clk) disable iff (rst)
    flags[FLG_TSE] |-> !slot_req);

  a_r5_tbe_cleared: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADDR_DATA)) |=> !flags[FLG_TBE]);

  a_r7_rbf_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FLG_RBF]) |-> $past(slot_req && slot_ack));

  a_r7_rbf_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADDR_DATA) && !done) |=> !flags[FLG_RBF]);
endmodule

bind owb_byte_engine owb_byte_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr),
  .slot_req(slot_req),
  .slot_bit(slot_bit),
  .slot_ack(slot_ack),
  .done    (done),
  .flags   (flags)
);

// File: tb/owb_byte_engine_tb.sv
module owb_byte_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, slot_req, slot_bit;
  logic       slot_ack = 1'b0, slot_sample = 1'b0;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit done_run = 0;

  bit exp_tx[$];
  bit dev_q[$];
  int wait_cnt = 0, slot_idx = 0;
  bit prev_req = 0, prev_ack = 0, prev_bit = 0;

  always #2.5 clk = ~clk;

  owb_byte_engine u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .slot_req(slot_req), .slot_bit(slot_bit), .slot_ack(slot_ack), .slot_sample(slot_sample)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference slot engine: variable ack delay, device pulls wire low per its queue
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_req && !prev_ack && slot_req)
        check("R3 held bit", slot_bit, prev_bit);
      prev_req = slot_req;
      prev_bit = slot_bit;
      if (slot_ack) begin
        slot_ack = 1'b0;
        wait_cnt = 0;
      end else if (slot_req) begin
        if (wait_cnt >= (slot_idx % 3)) begin
          bit e, d;
          e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 1'b0;
          check("R2 slot bit order", slot_bit, e);
          d = (dev_q.size() > 0) ? dev_q.pop_front() : 1'b1;
          slot_sample = slot_bit & d;
          slot_ack = 1'b1;
          slot_idx++;
        end else begin
          wait_cnt++;
        end
      end
      prev_ack = slot_ack;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd0) for (int i = 0; i < 8; i++) exp_tx.push_back(d[i]);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic dev_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) dev_q.push_back(d[i]);
  endtask

  task automatic wait_tse(output bit ok);
    logic [7:0] f;
    ok = 0;
    for (int n = 0; n < 500; n++) begin
      bus_read(2'd1, f);
      if (f[3]) begin ok = 1; break; end
    end
  endtask

  initial begin
    logic [7:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 slot_req", slot_req, 0);
    bus_read(2'd1, v); check("R1/R11 flags", v, 8'h2C);
    bus_read(2'd0, v); check("R1 data", v, 8'h00);

    // Mixed byte, device clears some bits
    dev_byte(8'h3C);
    bus_write(2'd0, 8'hA5);
    bus_read(2'd1, v); check("R5 tbe clear after write", v, 8'h20);
    bus_read(2'd1, v); check("R5/R8 tbe set, shifting", v, 8'h04);
    wait_tse(ok); check("R6 tse sets", ok, 1);
    check("R6 all slots sent", exp_tx.size(), 0);
    bus_read(2'd1, v); check("R7 rbf set", v, 8'h3C);
    bus_read(2'd0, v); check("R4 rx byte", v, 8'hA5 & 8'h3C);
    bus_read(2'd1, v); check("R7 rbf cleared by read", v, 8'h2C);

    // Read byte: transmit all ones
    dev_byte(8'h96);
    bus_write(2'd0, 8'hFF);
    wait_tse(ok); check("R6 tse after read byte", ok, 1);
    bus_read(2'd0, v); check("R4 read via 0xFF", v, 8'h96);

    // Back to back
    dev_byte(8'hFF); dev_byte(8'hF0);
    bus_write(2'd0, 8'h12);
    bus_write(2'd0, 8'h34);
    bus_read(2'd1, v); check("R10 second byte held", v[2], 0);
    wait_tse(ok); check("R10 tse after both", ok, 1);
    check("R10 both bytes sent before tse", exp_tx.size(), 0);
    bus_read(2'd0, v); check("R10 last rx byte", v, 8'h34 & 8'hF0);

    // Interrupt mask
    bus_write(2'd2, 8'h10);
    check("R9 irq masked", irq, 0);
    bus_read(2'd2, v); check("R9 enable readback", v, 8'h10);
    dev_byte(8'hFF);
    bus_write(2'd0, 8'h0F);
    wait_tse(ok);
    check("R9 irq on rbf", irq, 1);
    bus_read(2'd0, v); check("R4 rx 0x0F", v, 8'h0F);
    check("R9 irq drops after read", irq, 0);
    bus_write(2'd2, 8'h08); check("R9 irq on tse", irq, 1);
    bus_write(2'd2, 8'h20); check("R9 irq on rsr", irq, 1);
    bus_write(2'd2, 8'h00); check("R9 irq all masked", irq, 0);

    done_run = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done_run || cycles > 100000) begin
      if (!done_run) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule